// File: doc/BRIEF.md
# Serial-Bus PHY Base Register Bank

This block holds the base configuration and status registers of a two-port serial-bus PHY. Software reaches it through a small address/data port with separate read and write strobes. Its fields fall into two groups. Some clear on every bus reset. Others survive a bus reset and return to their defaults only on hardware reset. The block also watches for a run of bus resets with no gap-count update between them, and in that case it restores the arbitration gap count to its maximum.

Software can request a long or a short bus reset by setting a request bit. A three-state machine turns a pending request into a single-cycle pulse on `brst_req`, with `brst_long` giving the type. The pulse waits until `port_busy` is low, so that any receive or transmit in progress can finish first.

- **States:** `BR_IDLE` means nothing is pending. `BR_WAIT` means a request is pending and the block is waiting for the port to go idle. `BR_FIRE` means the pulse is being issued.
- **Transitions:** `IDLE->WAIT` happens when a request bit is set and no bus reset occurs. `WAIT->IDLE` happens on a bus reset, or when software clears both request bits. `WAIT->FIRE` happens when `port_busy` is sampled low. `FIRE->IDLE` happens always, after one cycle.

The block also drives the self-ID link-active, contender and power-class bits, and the link-on wake output.

Top module: `phy_base_regs`

## Requirements
- R1: A hardware reset (`rst_n` low on a clock edge) leaves the registers in this state:
  - gap count = 3Fh and link control = 1;
  - root-holdoff, both request bits and watchdog enable = 0;
  - root and ID-valid = 0, and physical ID = 0;
  - contender and power class are loaded from `contend_pin` and `pwr_pins`;
  - `rd_data` = 0.
- R2: Read data is registered. A read with `rd_en` loads `rd_data` at that clock edge, and otherwise `rd_data` holds. The read-only addresses return fixed values:
  - address 3 returns 17h (extended field 111b in [2:0], port count 00010b in [7:3]);
  - address 4 returns 02h (speed 010b in [2:0], delay 0 in [6:3]);
  - address 5 (jitter) returns 00h;
  - addresses 6 and 7 return 00h.
- R3: Address 0 reads as {valid[7], root[6], phy_id[5:0]}.
  - `selfid_done` latches `selfid_phy_id` and sets valid.
  - `tree_root` sets root.
  - `bus_rst` clears valid and root, and it wins over `selfid_done` or `tree_root` in the same cycle.
- R4: A bus reset clears both reset-request bits, root and valid. It leaves root-holdoff, link control, contender, power class and watchdog enable unchanged.
- R5: The gap count returns to 3Fh on a bus reset that follows an earlier bus reset with no gap-count update in between.
  - An update is a write to address 1 or a `cfg_gap_wr` strobe.
  - `cfg_gap` wins over a register write in the same cycle.
  - An update in the same cycle as a bus reset takes effect and counts as intervening.
- R6: A pending request produces a `brst_req` pulse exactly one cycle long. The pulse comes in the cycle after the first clock edge, at least one edge after the bit was set, at which `port_busy` is low.
- R7: When the long request is pending at the pulse, `brst_long` is 1; the long reset wins over a short one. The pulse clears both request bits, and the clear wins over a write in the same cycle. A pulse is issued only if a request is still set in the firing cycle.
- R8: `sid_l` = link control AND `lps`; `sid_c` = contender bit; `sid_pwr` = power class.
- R9: `linkon` is 1 exactly when watchdog enable is 1, `lps` is 0 and at least one of `int_cable_to`, `int_cable_pwr`, `int_state_to` is 1.
- R10: Address 1 reads and writes {holdoff[7], long_req[6], gap[5:0]}. Address 2 reads and writes {0[7], short_req[6], wdie[5], pwr[4:2], contender[1], lctrl[0]}. Writes to addresses 0 and 3–7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous hardware reset, active low |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| bus_rst | input | 1 | Bus reset occurred (one-cycle pulse) |
| selfid_done | input | 1 | Self-ID complete strobe |
| selfid_phy_id | input | 6 | Physical ID assigned during self-ID |
| tree_root | input | 1 | Node won root during tree identification |
| cfg_gap_wr | input | 1 | PHY configuration packet carries a gap count |
| cfg_gap | input | 6 | Gap count from that packet |
| port_busy | input | 1 | Receive or transmit in progress |
| lps | input | 1 | Link power status, high = link active |
| contend_pin | input | 1 | Contender strap, sampled at hardware reset |
| pwr_pins | input | 3 | Power-class straps, sampled at hardware reset |
| int_cable_to | input | 1 | Cable-timeout interrupt flag |
| int_cable_pwr | input | 1 | Cable-power interrupt flag |
| int_state_to | input | 1 | State-timeout interrupt flag |
| brst_req | output | 1 | One-cycle bus-reset request pulse |
| brst_long | output | 1 | Request type: 1 long, 0 short (valid with `brst_req`) |
| sid_l | output | 1 | Self-ID link-active bit |
| sid_c | output | 1 | Self-ID contender bit |
| sid_pwr | output | 3 | Self-ID power-class field |
| linkon | output | 1 | Link wake request |

## Verification
The assertions assume that `bus_rst`, `selfid_done`, `tree_root` and `cfg_gap_wr` are single-cycle event strobes sampled on the clock. They also assume that `port_busy` and `lps` are synchronous levels, so a sampled-low busy in one cycle can be related to the pulse in the next. The stimulus drives every input at the falling edge from a seeded `$urandom` stream, keeping the event strobes sparse so that coincidences still occur. Directed sequences cover these cases:
- back-to-back bus resets;
- a configuration packet racing a register write;
- a long and a short request pending together while the port is held busy;
- each wake-source flag with the link both active and inactive.

// File: rtl/phy_base_pkg.sv
package phy_base_pkg;
    localparam int REG_W  = 8;
    localparam int ID_W   = 6;
    localparam int GAP_W  = 6;
    localparam int PWR_W  = 3;
    localparam int ADDR_W = 3;

    localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

    localparam logic [ADDR_W-1:0] A_IDENT  = 3'd0;
    localparam logic [ADDR_W-1:0] A_ARB    = 3'd1;
    localparam logic [ADDR_W-1:0] A_NODE   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAPS   = 3'd3;
    localparam logic [ADDR_W-1:0] A_TIMING = 3'd4;
    localparam logic [ADDR_W-1:0] A_JITTER = 3'd5;

    // capability: port count 2 in [7:3], extended set 7 in [2:0]
    localparam logic [REG_W-1:0] RO_CAPS   = {5'd2, 3'd7};
    // timing: delay 0 in [6:3], speed code 2 in [2:0]
    localparam logic [REG_W-1:0] RO_TIMING = {1'b0, 4'd0, 3'd2};
    localparam logic [REG_W-1:0] RO_JITTER = '0;

    typedef enum logic [1:0] {
        BR_IDLE,
        BR_WAIT,
        BR_FIRE
    } brst_state_e;
endpackage

// File: rtl/phy_gap_track.sv
module phy_gap_track
    import phy_base_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst,
    input  logic             wr_upd,
    input  logic [GAP_W-1:0] wr_val,
    input  logic             cfg_upd,
    input  logic [GAP_W-1:0] cfg_val,
    output logic [GAP_W-1:0] gap,
    output logic             quiet
);
    // quiet: a bus reset has been seen with no update since
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap   <= GAP_MAX;
            quiet <= 1'b0;
        end else if (cfg_upd || wr_upd) begin
            gap   <= cfg_upd ? cfg_val : wr_val;
            quiet <= 1'b0;
        end else if (bus_rst) begin
            if (quiet) begin
                gap <= GAP_MAX;
            end
            quiet <= 1'b1;
        end
    end
endmodule

// File: rtl/phy_busrst_fsm.sv
module phy_busrst_fsm
    import phy_base_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rst,
    input  logic long_pend,
    input  logic short_pend,
    input  logic busy,
    output logic req,
    output logic req_long,
    output logic clr
);
    brst_state_e state, nxt;
    logic pend;

    assign pend = long_pend || short_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BR_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            BR_IDLE: begin
                if (!bus_rst && pend) begin
                    nxt = BR_WAIT;
                end
            end
            BR_WAIT: begin
                if (bus_rst || !pend) begin
                    nxt = BR_IDLE;
                end else if (!busy) begin
                    nxt = BR_FIRE;
                end
            end
            BR_FIRE: nxt = BR_IDLE;
            default: nxt = BR_IDLE;
        endcase
    end

    always_comb begin
        req      = (state == BR_FIRE) && pend;
        req_long = (state == BR_FIRE) && long_pend;
        clr      = (state == BR_FIRE);
    end
endmodule

// File: rtl/phy_linkstat.sv
module phy_linkstat
    import phy_base_pkg::*;
(
    input  logic             lctrl,
    input  logic             lps,
    input  logic             contender,
    input  logic [PWR_W-1:0] pwr,
    input  logic             wdie,
    input  logic [2:0]       wake_flags,
    output logic             sid_l,
    output logic             sid_c,
    output logic [PWR_W-1:0] sid_pwr,
    output logic             linkon
);
    always_comb begin
        sid_l   = lctrl && lps;
        sid_c   = contender;
        sid_pwr = pwr;
        linkon  = wdie && !lps && (|wake_flags);
    end
endmodule

// File: rtl/phy_base_regs.sv
module phy_base_regs
    import phy_base_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rd_data,
    input  logic              bus_rst,
    input  logic              selfid_done,
    input  logic [ID_W-1:0]   selfid_phy_id,
    input  logic              tree_root,
    input  logic              cfg_gap_wr,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              port_busy,
    input  logic              lps,
    input  logic              contend_pin,
    input  logic [PWR_W-1:0]  pwr_pins,
    input  logic              int_cable_to,
    input  logic              int_cable_pwr,
    input  logic              int_state_to,
    output logic              brst_req,
    output logic              brst_long,
    output logic              sid_l,
    output logic              sid_c,
    output logic [PWR_W-1:0]  sid_pwr,
    output logic              linkon
);
    logic [ID_W-1:0]  phy_id;
    logic             id_valid, root_q;
    logic             holdoff_q, long_q, short_q;
    logic             lctrl_q, cont_q, wdie_q;
    logic [PWR_W-1:0] pwr_q;
    logic [GAP_W-1:0] gap_q;
    logic             gap_quiet, gap_upd;
    logic             wr_arb, wr_node, req_clr;

    assign wr_arb  = wr_en && (addr == A_ARB);
    assign wr_node = wr_en && (addr == A_NODE);
    assign gap_upd = wr_arb || cfg_gap_wr;

    phy_gap_track u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_rst (bus_rst),
        .wr_upd  (wr_arb),
        .wr_val  (wr_data[GAP_W-1:0]),
        .cfg_upd (cfg_gap_wr),
        .cfg_val (cfg_gap),
        .gap     (gap_q),
        .quiet   (gap_quiet)
    );

    phy_busrst_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rst    (bus_rst),
        .long_pend  (long_q),
        .short_pend (short_q),
        .busy       (port_busy),
        .req        (brst_req),
        .req_long   (brst_long),
        .clr        (req_clr)
    );

    phy_linkstat u_link (
        .lctrl      (lctrl_q),
        .lps        (lps),
        .contender  (cont_q),
        .pwr        (pwr_q),
        .wdie       (wdie_q),
        .wake_flags ({int_cable_to, int_cable_pwr, int_state_to}),
        .sid_l      (sid_l),
        .sid_c      (sid_c),
        .sid_pwr    (sid_pwr),
        .linkon     (linkon)
    );

    // identity fields: bus reset wins over self-ID and tree-ID events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_id   <= '0;
            id_valid <= 1'b0;
            root_q   <= 1'b0;
        end else begin
            if (bus_rst) begin
                id_valid <= 1'b0;
            end else if (selfid_done) begin
                id_valid <= 1'b1;
                phy_id   <= selfid_phy_id;
            end
            if (bus_rst) begin
                root_q <= 1'b0;
            end else if (tree_root) begin
                root_q <= 1'b1;
            end
        end
    end

    // fields kept across bus reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            holdoff_q <= 1'b0;
            lctrl_q   <= 1'b1;
            cont_q    <= contend_pin;
            pwr_q     <= pwr_pins;
            wdie_q    <= 1'b0;
        end else begin
            if (wr_arb) begin
                holdoff_q <= wr_data[7];
            end
            if (wr_node) begin
                lctrl_q <= wr_data[0];
                cont_q  <= wr_data[1];
                pwr_q   <= wr_data[4:2];
                wdie_q  <= wr_data[5];
            end
        end
    end

    // request bits: bus reset or issue clears, ahead of writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            long_q  <= 1'b0;
            short_q <= 1'b0;
        end else if (bus_rst || req_clr) begin
            long_q  <= 1'b0;
            short_q <= 1'b0;
        end else begin
            if (wr_arb) begin
                long_q <= wr_data[6];
            end
            if (wr_node) begin
                short_q <= wr_data[6];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            unique case (addr)
                A_IDENT:  rd_data <= {id_valid, root_q, phy_id};
                A_ARB:    rd_data <= {holdoff_q, long_q, gap_q};
                A_NODE:   rd_data <= {1'b0, short_q, wdie_q, pwr_q, cont_q, lctrl_q};
                A_CAPS:   rd_data <= RO_CAPS;
                A_TIMING: rd_data <= RO_TIMING;
                A_JITTER: rd_data <= RO_JITTER;
                default:  rd_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/phy_base_regs_chk.sv
module phy_base_regs_chk
    import phy_base_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rst,
    input logic             port_busy,
    input logic             lps,
    input logic             brst_req,
    input logic             brst_long,
    input logic             sid_l,
    input logic             linkon,
    input logic             id_valid,
    input logic [GAP_W-1:0] gap,
    input logic             quiet,
    input logic             upd,
    input logic             long_pend,
    input logic             short_pend
);
    p_valid_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> !id_valid);

    p_gap_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst && quiet && !upd) |=> (gap == GAP_MAX));

    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        brst_req |=> !brst_req);

    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        brst_req |-> !$past(port_busy));

    p_long_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (brst_req && long_pend) |-> brst_long);

    p_req_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        brst_req |=> (!long_pend && !short_pend));

    p_sid_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sid_l |-> lps);

    p_linkon_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        linkon |-> !lps);
endmodule

bind phy_base_regs phy_base_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rst    (bus_rst),
    .port_busy  (port_busy),
    .lps        (lps),
    .brst_req   (brst_req),
    .brst_long  (brst_long),
    .sid_l      (sid_l),
    .linkon     (linkon),
    .id_valid   (id_valid),
    .gap        (gap_q),
    .quiet      (gap_quiet),
    .upd        (gap_upd),
    .long_pend  (long_q),
    .short_pend (short_q)
);

// File: tb/phy_base_regs_bench.sv
module phy_base_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] addr;
    logic       wr_en, rd_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       bus_rst, selfid_done, tree_root, cfg_gap_wr, port_busy, lps;
    logic [5:0] selfid_phy_id, cfg_gap;
    logic       contend_pin;
    logic [2:0] pwr_pins;
    logic       int_cable_to, int_cable_pwr, int_state_to;
    logic       brst_req, brst_long, sid_l, sid_c, linkon;
    logic [2:0] sid_pwr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    phy_base_regs u_phy_base_regs (.*);

    // reference model, built from the requirements
    logic [5:0] m_id, m_gap;
    logic       m_valid, m_root, m_hold, m_long, m_short, m_quiet;
    logic       m_lctrl, m_cont, m_wdie;
    logic [2:0] m_pwr;
    int         m_st, n_st;
    logic [7:0] m_rd;
    logic       m_w1, m_w2, m_fire, m_pend;

    function automatic logic [7:0] mread(input logic [2:0] a);
        case (a)
            3'd0: mread = {m_valid, m_root, m_id};
            3'd1: mread = {m_hold, m_long, m_gap};
            3'd2: mread = {1'b0, m_short, m_wdie, m_pwr, m_cont, m_lctrl};
            3'd3: mread = 8'h17;
            3'd4: mread = 8'h02;
            default: mread = 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_id = '0; m_valid = 0; m_root = 0; m_hold = 0; m_long = 0; m_short = 0;
            m_gap = 6'h3F; m_quiet = 0; m_lctrl = 1; m_cont = contend_pin;
            m_pwr = pwr_pins; m_wdie = 0; m_st = 0; m_rd = '0;
        end else begin
            if (rd_en) m_rd = mread(addr);
            m_fire = (m_st == 2);
            m_pend = m_long || m_short;
            case (m_st)
                0: n_st = (!bus_rst && m_pend) ? 1 : 0;
                1: n_st = (bus_rst || !m_pend) ? 0 : (!port_busy ? 2 : 1);
                default: n_st = 0;
            endcase
            m_w1 = wr_en && addr == 3'd1;
            m_w2 = wr_en && addr == 3'd2;
            if (m_w1) m_hold = wr_data[7];
            if (m_w2) begin
                m_lctrl = wr_data[0]; m_cont = wr_data[1];
                m_pwr = wr_data[4:2]; m_wdie = wr_data[5];
            end
            if (bus_rst || m_fire) begin
                m_long = 0; m_short = 0;
            end else begin
                if (m_w1) m_long = wr_data[6];
                if (m_w2) m_short = wr_data[6];
            end
            if (cfg_gap_wr || m_w1) begin
                m_gap = cfg_gap_wr ? cfg_gap : wr_data[5:0];
                m_quiet = 0;
            end else if (bus_rst) begin
                if (m_quiet) m_gap = 6'h3F;
                m_quiet = 1;
            end
            if (bus_rst) m_valid = 0;
            else if (selfid_done) begin m_valid = 1; m_id = selfid_phy_id; end
            if (bus_rst) m_root = 0;
            else if (tree_root) m_root = 1;
            m_st = n_st;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // advance one clock; at the falling edge compare ports with the model
    task automatic step();
        @(negedge clk);
        chk("R2 rd_data", rd_data, m_rd);
        chk("R6 brst_req", {7'd0, brst_req}, {7'd0, (m_st == 2) && (m_long || m_short)});
        chk("R7 brst_long", {7'd0, brst_long}, {7'd0, (m_st == 2) && m_long});
        chk("R8 sid_l", {7'd0, sid_l}, {7'd0, m_lctrl && lps});
        chk("R8 sid_c/pwr", {4'd0, sid_c, sid_pwr}, {4'd0, m_cont, m_pwr});
        chk("R9 linkon", {7'd0, linkon},
            {7'd0, m_wdie && !lps && (int_cable_to || int_cable_pwr || int_state_to)});
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; bus_rst = 0; selfid_done = 0; tree_root = 0; cfg_gap_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        idle(); addr = a; rd_en = 1;
        step();
        rd_en = 0;
        chk(tag, rd_data, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        idle(); addr = a; wr_data = d; wr_en = 1;
        step();
        wr_en = 0;
    endtask

    task automatic pulse_busrst();
        idle(); bus_rst = 1; step(); bus_rst = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        rst_n = 0; idle(); addr = 0; wr_data = 0; selfid_phy_id = 0; cfg_gap = 0;
        port_busy = 0; lps = 1; contend_pin = 1; pwr_pins = 3'b101;
        int_cable_to = 0; int_cable_pwr = 0; int_state_to = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state, R2 fixed fields
        rd(3'd1, 8'h3F, "R1 arb reg");
        rd(3'd2, 8'h17, "R1 node reg");
        rd(3'd0, 8'h00, "R1 ident reg");
        rd(3'd3, 8'h17, "R2 caps");
        rd(3'd4, 8'h02, "R2 timing");
        rd(3'd5, 8'h00, "R2 jitter");
        rd(3'd7, 8'h00, "R2 unused");

        // R3 identity and root
        idle(); selfid_done = 1; selfid_phy_id = 6'h2A; step();
        idle(); tree_root = 1; step();
        rd(3'd0, 8'hEA, "R3 id valid root");
        pulse_busrst();
        rd(3'd0, 8'h2A, "R3 cleared by bus reset");

        // R10 layout, R4 retention
        wr(3'd1, 8'h95);
        wr(3'd2, 8'h22);
        wr(3'd0, 8'hFF);
        rd(3'd0, 8'h2A, "R10 ident not writable");
        pulse_busrst();
        rd(3'd1, 8'h95, "R4 holdoff and gap kept");
        rd(3'd2, 8'h22, "R4 node fields kept");

        // R5 gap count recovery
        pulse_busrst();
        rd(3'd1, 8'hBF, "R5 second bus reset");
        idle(); cfg_gap_wr = 1; cfg_gap = 6'h0A; step(); cfg_gap_wr = 0;
        pulse_busrst();
        rd(3'd1, 8'h8A, "R5 packet update kept");
        pulse_busrst();
        rd(3'd1, 8'hBF, "R5 default again");
        idle(); addr = 3'd1; wr_data = 8'h07; wr_en = 1; cfg_gap_wr = 1; cfg_gap = 6'h09;
        step(); idle();
        rd(3'd1, 8'h09, "R5 packet wins");

        // R6/R7 request handling
        port_busy = 1;
        wr(3'd1, 8'h49);
        wr(3'd2, 8'h41);
        repeat (4) begin
            step();
            chk("R6 held while busy", {7'd0, brst_req}, 8'd0);
        end
        port_busy = 0;
        step();
        chk("R6 pulse", {7'd0, brst_req}, 8'd1);
        chk("R7 long wins", {7'd0, brst_long}, 8'd1);
        step();
        chk("R6 one cycle", {7'd0, brst_req}, 8'd0);
        rd(3'd1, 8'h09, "R7 long cleared");
        rd(3'd2, 8'h01, "R7 short cleared");
        wr(3'd2, 8'h41);
        step();
        step();
        chk("R6 short pulse", {7'd0, brst_req}, 8'd1);
        chk("R7 short type", {7'd0, brst_long}, 8'd0);

        // R8 self-ID bits
        idle(); lps = 1; step();
        chk("R8 L active", {7'd0, sid_l}, 8'd1);
        lps = 0; step();
        chk("R8 L inactive", {7'd0, sid_l}, 8'd0);
        wr(3'd2, 8'h1F);
        chk("R8 c/pwr", {4'd0, sid_c, sid_pwr}, 8'h0F);

        // R9 wake output
        wr(3'd2, 8'h3F);
        int_cable_pwr = 1; step();
        chk("R9 wake", {7'd0, linkon}, 8'd1);
        lps = 1; step();
        chk("R9 link active", {7'd0, linkon}, 8'd0);
        lps = 0; int_cable_pwr = 0; int_state_to = 1; step();
        chk("R9 state timeout", {7'd0, linkon}, 8'd1);
        wr(3'd2, 8'h1F);
        chk("R9 disabled", {7'd0, linkon}, 8'd0);
        int_state_to = 0;

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            addr          = 3'($urandom % 8);
            wr_en         = ($urandom % 4) == 0;
            wr_data       = 8'($urandom);
            rd_en         = ($urandom % 2) == 0;
            bus_rst       = ($urandom % 20) == 0;
            selfid_done   = ($urandom % 16) == 0;
            selfid_phy_id = 6'($urandom);
            tree_root     = ($urandom % 16) == 0;
            cfg_gap_wr    = ($urandom % 24) == 0;
            cfg_gap       = 6'($urandom);
            port_busy     = ($urandom % 3) != 0;
            lps           = ($urandom % 2) == 0;
            int_cable_to  = ($urandom % 5) == 0;
            int_cable_pwr = ($urandom % 5) == 0;
            int_state_to  = ($urandom % 5) == 0;
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule